// File: doc/BRIEF.md
# Serial SAR Converter Sequencer

This block is the digital heart of an 8-bit successive-approximation converter that talks to its host over a few-wire serial link. It runs on the serial clock. While the select line is low, it waits for a start bit on the data input. It then shifts in a short channel-address word, allows one clock for the multiplexer to settle, and then resolves one result bit per clock. On each step it presents a trial code to an external comparator and reads back a one-bit decision.

Each resolved bit leaves on the data output at the falling edge after the rising edge that decided it, MSB first. In multi-channel variants the stored result is then sent again LSB first, paced by a shift-enable input. A parameter picks a 1-, 2-, 4- or 8-input variant. In the smaller variants the address word is shorter and some multiplexer select bits are tied to fixed values. The analog multiplexer and comparator sit outside the block. The block only tells them which input is positive and which is negative.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, and at the falling edge after any rising edge that sees the select line high, the output enable and the busy line are both low.
- R2: While select is low, zeros on the data input at rising edges are ignored and leave the output disabled; the first 1 sampled is the start bit.
- R3: After the start bit, the address bits are sampled on the following rising edges. The 8-input variant takes 4 bits in the order single-ended, odd, sel1, sel0. The 4-input variant takes 3 bits (single-ended, odd, sel1) and holds sel0 at 1. The 2-input variant takes 2 bits (single-ended, odd) and holds sel1 at 1 and sel0 at 0. The 1-input variant takes none and is fixed as differential with odd, sel1 and sel0 all 0.
- R4: One rising edge after the last address bit (or after the start bit in the 1-input variant) is a settling edge. At the falling edge after it, the output is enabled and drives a leading 0, and the trial code is 0x80.
- R5: Each of the next 8 rising edges decides one bit from MSB down. The bit is kept when the comparator input is 1. Between decisions the trial code equals the kept upper bits plus a 1 in the bit under test.
- R6: The positive mux select is {sel1,sel0,odd} and the negative select is {sel1,sel0,~odd}. The negative side is the common input when single-ended is 1. The result equals the positive minus the negative value, clamped to 0..255. Result bits appear MSB first, each at the falling edge after the rising edge that decided it.
- R7: Busy is high from the falling edge after the settling edge until the falling edge after the LSB decision, where it goes low.
- R8: In the 2-, 4- and 8-input variants, bits 1 to 7 follow LSB first without repeating bit 0. Each bit appears at the falling edge after a rising edge that sees shift-enable high. Shift-enable low holds the data output unchanged.
- R9: At the falling edge after the rising edge that follows the final bit, the output enable goes low and stays low while select remains low.
- R10: Taking select high during a conversion aborts it: output enable and busy are low at the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; inputs sampled on rising edges, outputs updated on falling edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high returns the sequencer to idle |
| di | input | 1 | Serial data in: start bit then address bits |
| se | input | 1 | Shift-enable pacing the LSB-first replay |
| cmp_i | input | 1 | Comparator decision: 1 when the input difference is at least the trial code |
| trial_o | output | RES_W | Trial code presented to the converter |
| pos_ch_o | output | 3 | Mux select for the positive input |
| neg_ch_o | output | 3 | Mux select for the negative input |
| neg_com_o | output | 1 | Negative input taken from the common terminal |
| do_o | output | 1 | Serial result data |
| do_oe_o | output | 1 | Output enable for do_o (low models high impedance) |
| busy_o | output | 1 | Conversion in progress |

## Verification
Inputs change at falling edges and the output pins also move on falling edges, so every pin check waits for a falling edge plus a small delay. A result bit is sampled one falling edge after the rising edge that decided it. The leading zero and first trial code are sampled one falling edge after the settling edge, which comes one edge after the last address bit. The disable after the final bit is sampled one full clock after that bit. The bench runs four instances, one per variant, and sweeps all address words under several input-value patterns, including both clamps. It computes expected codes by arithmetic on those values, and it adds lead-in zeros, replay stalls and an abort per variant.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SETTLE,
    ST_CONV,
    ST_REPLAY,
    ST_DONE
  } seq_state_e;

  // number of address bits shifted in for a given input count
  function automatic int addr_bits(input int nch);
    case (nch)
      8:       return 4;
      4:       return 3;
      2:       return 2;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       di,
  input  logic                       se,
  output seq_state_e                 state_o,
  output logic [$clog2(RES_W)-1:0]   cnt_o
);

  localparam int CW        = $clog2(RES_W);
  localparam int AW        = addr_bits(NCH);
  localparam bit REPLAY_EN = (NCH > 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(RES_W - 1);
  localparam logic [CW-1:0] ALAST    = (AW > 0) ? CW'(AW - 1) : '0;

  seq_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (cs_n) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (di) begin
            cnt_d = '0;
            if (AW > 0) st_d = ST_ADDR;
            else        st_d = ST_SETTLE;
          end
        end
        ST_ADDR: begin
          if (cnt_q == ALAST) st_d = ST_SETTLE;
          else                cnt_d = cnt_q + 1'b1;
        end
        ST_SETTLE: begin
          st_d  = ST_CONV;
          cnt_d = LAST_BIT;
        end
        ST_CONV: begin
          if (cnt_q == '0) begin
            if (REPLAY_EN) st_d = ST_REPLAY;
            else           st_d = ST_DONE;
            cnt_d = CW'(1);
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        ST_REPLAY: begin
          if (se) begin
            if (cnt_q == LAST_BIT) st_d = ST_DONE;
            else                   cnt_d = cnt_q + 1'b1;
          end
        end
        ST_DONE: begin
          st_d = ST_DONE;
        end
        default: begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o = st_q;
  assign cnt_o   = cnt_q;

  // R10: select high always lands the sequencer in idle
  a_r10_cs_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (st_q == ST_IDLE));

  // R5: one bit position per clock during conversion
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && st_q == ST_CONV && cnt_q != '0) |=>
      (st_q == ST_CONV && cnt_q == $past(cnt_q) - 1'b1));

  // R8: replay waits while shift-enable is low
  a_r8_replay_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && st_q == ST_REPLAY && !se) |=> (st_q == ST_REPLAY && $stable(cnt_q)));

endmodule

// File: rtl/sar_seq_addr.sv
module sar_seq_addr
  import sar_seq_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en_i,
  input  logic       hold_i,
  input  logic       di,
  output logic [2:0] pos_ch_o,
  output logic [2:0] neg_ch_o,
  output logic       neg_com_o
);

  localparam int AW = addr_bits(NCH);

  logic sgl, odd, sel1, sel0;

  generate
    if (AW > 0) begin : g_shift
      logic [AW-1:0] sh_q, sh_d;

      always_comb begin
        sh_d = sh_q;
        if (shift_en_i) sh_d = {sh_q[AW-1:0], di} >> 0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
      end

      if (NCH == 8) begin : g_eight
        assign sgl  = sh_q[3];
        assign odd  = sh_q[2];
        assign sel1 = sh_q[1];
        assign sel0 = sh_q[0];
      end else if (NCH == 4) begin : g_four
        assign sgl  = sh_q[2];
        assign odd  = sh_q[1];
        assign sel1 = sh_q[0];
        assign sel0 = 1'b1;
      end else begin : g_two
        assign sgl  = sh_q[1];
        assign odd  = sh_q[0];
        assign sel1 = 1'b1;
        assign sel0 = 1'b0;
      end
    end else begin : g_fixed
      assign sgl  = 1'b0;
      assign odd  = 1'b0;
      assign sel1 = 1'b0;
      assign sel0 = 1'b0;
    end
  endgenerate

  assign pos_ch_o  = {sel1, sel0, odd};
  assign neg_ch_o  = {sel1, sel0, ~odd};
  assign neg_com_o = sgl;

  // R3: the mux selection holds once the address phase is over
  a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && !shift_en_i) |=> $stable({pos_ch_o, neg_ch_o, neg_com_o}));

endmodule

// File: rtl/sar_seq_approx.sv
module sar_seq_approx #(
  parameter int RES_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear_i,
  input  logic                     step_i,
  input  logic [$clog2(RES_W)-1:0] bit_i,
  input  logic                     cmp_i,
  output logic [RES_W-1:0]         trial_o,
  output logic [RES_W-1:0]         result_o
);

  logic [RES_W-1:0] sar_q, sar_d, probe;

  assign probe = RES_W'(1) << bit_i;

  always_comb begin
    sar_d = sar_q;
    if (clear_i)             sar_d = '0;
    else if (step_i && cmp_i) sar_d = sar_q | probe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sar_q <= '0;
    else        sar_q <= sar_d;
  end

  assign trial_o  = step_i ? (sar_q | probe) : sar_q;
  assign result_o = sar_q;

  // R5: no more than one bit changes per decision
  a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> ($countones(result_o ^ $past(result_o)) <= 1));

  // R5: a low comparator keeps the code unchanged
  a_r5_drop_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !cmp_i) |=> $stable(result_o));

endmodule

// File: rtl/sar_seq_dout.sv
module sar_seq_dout
  import sar_seq_pkg::*;
#(
  parameter int RES_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cs_n,
  input  logic                     se,
  input  seq_state_e               state_i,
  input  logic [$clog2(RES_W)-1:0] cnt_i,
  input  logic                     cmp_i,
  input  logic [RES_W-1:0]         result_i,
  output logic                     do_o,
  output logic                     do_oe_o,
  output logic                     busy_o
);

  // rising-edge stage: value to present at the next falling edge
  logic d_q, d_d, oe_q, oe_d, b_q, b_d;

  always_comb begin
    d_d  = d_q;
    oe_d = oe_q;
    b_d  = b_q;
    if (cs_n) begin
      d_d  = 1'b0;
      oe_d = 1'b0;
      b_d  = 1'b0;
    end else begin
      unique case (state_i)
        ST_IDLE, ST_ADDR: begin
          d_d  = 1'b0;
          oe_d = 1'b0;
          b_d  = 1'b0;
        end
        ST_SETTLE: begin
          d_d  = 1'b0;
          oe_d = 1'b1;
          b_d  = 1'b1;
        end
        ST_CONV: begin
          d_d = cmp_i;
          b_d = (cnt_i != '0);
        end
        ST_REPLAY: begin
          if (se) d_d = result_i[cnt_i];
        end
        ST_DONE: begin
          oe_d = 1'b0;
          b_d  = 1'b0;
        end
        default: begin
          oe_d = 1'b0;
          b_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q  <= 1'b0;
      oe_q <= 1'b0;
      b_q  <= 1'b0;
    end else begin
      d_q  <= d_d;
      oe_q <= oe_d;
      b_q  <= b_d;
    end
  end

  // falling-edge stage: pins
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      do_o    <= 1'b0;
      do_oe_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      do_o    <= d_q;
      do_oe_o <= oe_q;
      busy_o  <= b_q;
    end
  end

  // R1: select high clears enable and busy
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!oe_q && !b_q));

  // R9: output stays disabled once the sequence is done
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && state_i == ST_DONE) |=> !oe_q);

  // R7: busy only rises out of the settling edge
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(b_q) |-> ($past(state_i) == ST_SETTLE));

  // R8: replay stalls keep the data bit unchanged
  a_r8_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && state_i == ST_REPLAY && !se) |=> $stable(d_q));

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_seq_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             di,
  input  logic             se,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [2:0]       pos_ch_o,
  output logic [2:0]       neg_ch_o,
  output logic             neg_com_o,
  output logic             do_o,
  output logic             do_oe_o,
  output logic             busy_o
);

  localparam int CW = $clog2(RES_W);

  seq_state_e       state;
  logic [CW-1:0]    cnt;
  logic [RES_W-1:0] result;
  logic             in_addr, in_conv, in_settle, hold_sel;

  assign in_addr   = (state == ST_ADDR)   && !cs_n;
  assign in_conv   = (state == ST_CONV)   && !cs_n;
  assign in_settle = (state == ST_SETTLE) && !cs_n;
  assign hold_sel  = (state == ST_SETTLE) || (state == ST_CONV) ||
                     (state == ST_REPLAY) || (state == ST_DONE);

  sar_seq_ctrl #(.NCH(NCH), .RES_W(RES_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .di      (di),
    .se      (se),
    .state_o (state),
    .cnt_o   (cnt)
  );

  sar_seq_addr #(.NCH(NCH)) addr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en_i (in_addr),
    .hold_i     (hold_sel),
    .di         (di),
    .pos_ch_o   (pos_ch_o),
    .neg_ch_o   (neg_ch_o),
    .neg_com_o  (neg_com_o)
  );

  sar_seq_approx #(.RES_W(RES_W)) approx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (in_settle),
    .step_i   (in_conv),
    .bit_i    (cnt),
    .cmp_i    (cmp_i),
    .trial_o  (trial_o),
    .result_o (result)
  );

  sar_seq_dout #(.RES_W(RES_W)) dout_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .se       (se),
    .state_i  (state),
    .cnt_i    (cnt),
    .cmp_i    (cmp_i),
    .result_i (result),
    .do_o     (do_o),
    .do_oe_o  (do_oe_o),
    .busy_o   (busy_o)
  );

endmodule

// File: tb/sar_adc_seq_tb_top.sv
module sar_adc_seq_tb_top;

  logic clk;
  logic rst_n;
  logic di;
  logic se;
  logic cs_n_r [4];

  logic       do_w    [4];
  logic       oe_w    [4];
  logic       busy_w  [4];
  logic [7:0] trial_w [4];
  logic [2:0] pos_w   [4];
  logic [2:0] neg_w   [4];
  logic       com_w   [4];
  logic       cmp_w   [4];

  int vin [8];
  int n_chk;
  int n_err;

  always #5 clk = ~clk;

  // variant g has 2**g inputs
  for (genvar g = 0; g < 4; g++) begin : gv
    assign cmp_w[g] = (vin[pos_w[g]] - (com_w[g] ? 0 : vin[neg_w[g]])) >= int'(trial_w[g]);

    sar_adc_seq #(.NCH(1 << g), .RES_W(8)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (cs_n_r[g]),
      .di        (di),
      .se        (se),
      .cmp_i     (cmp_w[g]),
      .trial_o   (trial_w[g]),
      .pos_ch_o  (pos_w[g]),
      .neg_ch_o  (neg_w[g]),
      .neg_com_o (com_w[g]),
      .do_o      (do_w[g]),
      .do_oe_o   (oe_w[g]),
      .busy_o    (busy_w[g])
    );
  end

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, expv, $time);
    end
  endtask

  task automatic run_conv(input int g, input int a, input int lead,
                          input bit abort_it, input bit stall);
    logic [3:0] av;
    logic sgl, odd, s1, s0;
    logic [2:0] p, n;
    int aw, df;
    logic [7:0] e, tr;
    av = a[3:0];
    aw = (g == 3) ? 4 : (g == 2) ? 3 : (g == 1) ? 2 : 0;
    sgl = av[3]; odd = av[2]; s1 = av[1]; s0 = av[0];
    case (g)
      2: s0 = 1'b1;
      1: begin s1 = 1'b1; s0 = 1'b0; end
      0: begin sgl = 1'b0; odd = 1'b0; s1 = 1'b0; s0 = 1'b0; end
      default: ;
    endcase
    p  = {s1, s0, odd};
    n  = {s1, s0, ~odd};
    df = vin[p] - (sgl ? 0 : vin[n]);
    if (df < 0)   df = 0;
    if (df > 255) df = 255;
    e = df[7:0];

    @(negedge clk);
    cs_n_r[g] = 1'b0; di = 1'b0; se = 1'b1;
    for (int i = 0; i < lead; i++) begin
      @(negedge clk); #2;
      chk(oe_w[g] == 1'b0, "R2 zeros before start", int'(oe_w[g]), 0);
    end
    di = 1'b1;
    for (int i = 0; i < aw; i++) begin
      @(negedge clk);
      di = av[3-i];
    end
    @(negedge clk);
    di = 1'b0;
    @(negedge clk); #2;
    chk(oe_w[g] == 1'b1, "R4 enable after settle", int'(oe_w[g]), 1);
    chk(do_w[g] == 1'b0, "R4 leading zero", int'(do_w[g]), 0);
    chk(trial_w[g] == 8'h80, "R4 first trial", int'(trial_w[g]), 128);
    chk(busy_w[g] == 1'b1, "R7 busy high", int'(busy_w[g]), 1);
    chk(pos_w[g] == p, "R3 positive select", int'(pos_w[g]), int'(p));
    chk(neg_w[g] == n, "R3 negative select", int'(neg_w[g]), int'(n));
    chk(com_w[g] == sgl, "R3 common select", int'(com_w[g]), int'(sgl));
    if (abort_it) begin
      cs_n_r[g] = 1'b1;
      @(negedge clk); #2;
      chk(oe_w[g] == 1'b0, "R10 abort enable", int'(oe_w[g]), 0);
      chk(busy_w[g] == 1'b0, "R10 abort busy", int'(busy_w[g]), 0);
      return;
    end
    for (int k = 7; k >= 0; k--) begin
      @(negedge clk); #2;
      chk(do_w[g] == e[k], "R6 MSB-first bit", int'(do_w[g]), int'(e[k]));
      chk(busy_w[g] == (k != 0), "R7 busy window", int'(busy_w[g]), int'(k != 0));
      if (k > 0) begin
        tr = ((e >> k) << k) | (8'd1 << (k - 1));
        chk(trial_w[g] == tr, "R5 trial code", int'(trial_w[g]), int'(tr));
      end
    end
    if (g > 0) begin
      for (int i = 1; i < 8; i++) begin
        if (stall && i == 3) begin
          se = 1'b0;
          repeat (2) begin
            @(negedge clk); #2;
            chk(do_w[g] == e[2], "R8 stall holds", int'(do_w[g]), int'(e[2]));
          end
          se = 1'b1;
        end
        @(negedge clk); #2;
        chk(do_w[g] == e[i], "R8 LSB-first bit", int'(do_w[g]), int'(e[i]));
        chk(oe_w[g] == 1'b1, "R8 enable during replay", int'(oe_w[g]), 1);
      end
    end
    @(negedge clk); #2;
    chk(oe_w[g] == 1'b0, "R9 disable after last bit", int'(oe_w[g]), 0);
    @(negedge clk); #2;
    chk(oe_w[g] == 1'b0, "R9 stays disabled", int'(oe_w[g]), 0);
    cs_n_r[g] = 1'b1;
    @(negedge clk); #2;
    chk(oe_w[g] == 1'b0 && busy_w[g] == 1'b0, "R1 idle after deselect", int'(oe_w[g]), 0);
  endtask

  initial begin
    #1_500_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    n_chk = 0; n_err = 0;
    clk = 1'b0; rst_n = 1'b0; di = 1'b0; se = 1'b1;
    for (int g = 0; g < 4; g++) cs_n_r[g] = 1'b1;
    for (int c = 0; c < 8; c++) vin[c] = 0;
    repeat (3) @(negedge clk);
    #2;
    for (int g = 0; g < 4; g++) begin
      chk(oe_w[g] == 1'b0, "R1 reset enable", int'(oe_w[g]), 0);
      chk(busy_w[g] == 1'b0, "R1 reset busy", int'(busy_w[g]), 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int g = 0; g < 4; g++) begin
      for (int seed = 0; seed < 6; seed++) begin
        for (int c = 0; c < 8; c++) begin
          if (seed < 4)       vin[c] = (seed * 97 + c * 61 + 13) % 300;
          else if (seed == 4) vin[c] = (c % 2 == 0) ? 299 : 0;
          else                vin[c] = 100;
        end
        for (int a = 0; a < ((g == 0) ? 1 : 16); a++)
          run_conv(g, a, a % 3, 1'b0, (a == 5) || (g != 0 && a == 0 && seed == 0));
      end
      run_conv(g, 3, 1, 1'b1, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule